// File: doc/BRIEF.md
# Collision Response Controller

This block chooses how a serial channel reacts when the collision detector fires. Each collision pulse is handled according to what the channel was doing at that moment: idle, receiving, or transmitting. It also depends on whether the first byte of the frame has already crossed the FIFO boundary. In the receive path, a collision aborts the frame. If the first byte has already been written to the receive FIFO, the block also clears the receive enable and raises a sticky receive-error flag. In the transmit path, every collision starts the jam/backoff procedure. A retry is granted only if the first transmit byte is still inside the transmit FIFO, and only up to a fixed number of automatic restarts. Otherwise the transmitter is disabled and a sticky transmit-error flag is set.

When deterministic resolution is enabled, collisions seen while idle or receiving also start the resolution countdown. The jam pattern, the backoff timer and the countdown itself live outside this block. Software clears the two error flags with explicit clear strobes. The restart count is reset when a frame finishes cleanly or when the transmitter is newly enabled.

Top module: `collision_resp_ctrl`

## Requirements
- R1: While reset is held (rst_n low), and on the first cycle after it, every output is 0.
- R2: A collision with activity idle (2'b00, or the unused code 2'b11) produces no abort, enable-clear, jam or restart output. res_start pulses one cycle later only if det_res_en was 1 with the collision.
- R3: A collision with activity receive (2'b01) while rx_first_stored is 0 pulses rx_abort one cycle later and leaves rx_en_clr and rx_err unchanged. res_start follows det_res_en as in R2.
- R4: A collision with activity receive while rx_first_stored is 1 pulses rx_abort and rx_en_clr one cycle later and sets rx_err. res_start follows det_res_en as in R2.
- R5: Every collision with activity transmit (2'b10) pulses jam_start one cycle later and never pulses res_start, whatever det_res_en is.
- R6: A transmit collision with tx_first_taken at 0 and fewer than MAX_RESTARTS restarts made arms a retry. The next backoff_done then pulses tx_restart one cycle later and counts one restart.
- R7: A transmit collision that arrives after MAX_RESTARTS (default 8) restarts have been made pulses tx_en_clr and sets tx_err one cycle later, and arms no retry.
- R8: A transmit collision with tx_first_taken at 1 pulses tx_en_clr and sets tx_err one cycle later, and arms no retry.
- R9: frame_done or tx_en_set resets the restart count to zero and drops any armed retry, so a full new set of MAX_RESTARTS restarts becomes available.
- R10: rx_err and tx_err hold their value until their clear strobe (rx_err_clr, tx_err_clr). A set and a clear in the same cycle leave the flag at 1.
- R11: backoff_done with no armed retry has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activity | input | 2 | 00 idle, 01 receiving, 10 transmitting, 11 treated as idle |
| rx_first_stored | input | 1 | First received byte already written to the receive FIFO |
| tx_first_taken | input | 1 | First transmit byte already moved to the output shift register |
| coll | input | 1 | Collision detected (one-cycle pulse) |
| backoff_done | input | 1 | Backoff interval expired (pulse) |
| det_res_en | input | 1 | Deterministic resolution enabled |
| frame_done | input | 1 | Frame finished without collision (pulse) |
| tx_en_set | input | 1 | Transmit enable newly set (pulse) |
| rx_err_clr | input | 1 | Software clear of rx_err |
| tx_err_clr | input | 1 | Software clear of tx_err |
| rx_abort | output | 1 | Abort current reception (pulse) |
| rx_en_clr | output | 1 | Clear receive enable (pulse) |
| rx_err | output | 1 | Sticky receive-error flag |
| jam_start | output | 1 | Start jam/backoff procedure (pulse) |
| tx_restart | output | 1 | Request transmit restart (pulse) |
| tx_en_clr | output | 1 | Clear transmit enable (pulse) |
| tx_err | output | 1 | Sticky transmit-error flag |
| res_start | output | 1 | Start resolution countdown (pulse) |

## Verification
The bench builds the block with its defaults: MAX_RESTARTS of 8 and a 4-bit restart counter. With these values, the exact boundary can be reached, where eight restarts succeed and the ninth collision disables the transmitter. The counter then holds 8, which leaves room above the limit in a 4-bit field. Clearing the count with frame_done and with tx_en_set in the middle of a retry run lets the bench show that a full new set of eight restarts becomes available again.

// File: rtl/crc_resp_pkg.sv
package crc_resp_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'b00,
    ACT_RX    = 2'b01,
    ACT_TX    = 2'b10,
    ACT_SPARE = 2'b11
  } act_e;

  typedef struct packed {
    logic rx_abort;
    logic rx_en_clr;
    logic rx_err_set;
    logic jam;
    logic tx_fail;
    logic want_retry;
    logic res_start;
  } resp_t;

  // Response to one collision; tx_fail covers both the taken-byte case and the limit.
  function automatic resp_t classify(input logic coll, input logic [1:0] act,
                                     input logic stored, input logic taken,
                                     input logic limit, input logic dres);
    resp_t r;
    r = '0;
    if (coll) begin
      unique case (act)
        ACT_RX: begin
          r.rx_abort   = 1'b1;
          r.rx_en_clr  = stored;
          r.rx_err_set = stored;
          r.res_start  = dres;
        end
        ACT_TX: begin
          r.jam        = 1'b1;
          r.tx_fail    = taken | limit;
          r.want_retry = ~(taken | limit);
        end
        default: r.res_start = dres;
      endcase
    end
    return r;
  endfunction

  function automatic logic reached_limit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/crc_classify.sv
module crc_classify
  import crc_resp_pkg::*;
(
  input  logic       coll,
  input  logic [1:0] activity,
  input  logic       rx_first_stored,
  input  logic       tx_first_taken,
  input  logic       at_limit,
  input  logic       det_res_en,
  output resp_t      resp
);
  always_comb
    resp = classify(coll, activity, rx_first_stored, tx_first_taken, at_limit, det_res_en);
endmodule

// File: rtl/crc_retry_ctr.sv
module crc_retry_ctr
  import crc_resp_pkg::*;
#(
  parameter int unsigned CNT_W        = 4,
  parameter int unsigned MAX_RESTARTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             backoff_done,
  input  logic             clr,
  output logic             fire,
  output logic             at_limit,
  output logic             pending,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RESTARTS);

  assign fire     = pending & backoff_done;
  assign at_limit = reached_limit(int'(count), MAX_RESTARTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      pending <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      pending <= 1'b0;
    end else begin
      if (fire && count < LIMIT) count <= count + 1'b1;
      if (arm)       pending <= 1'b1;
      else if (fire) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/crc_sticky_flag.sv
module crc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/collision_resp_ctrl.sv
module collision_resp_ctrl
  import crc_resp_pkg::*;
#(
  parameter int unsigned CNT_W        = 4,
  parameter int unsigned MAX_RESTARTS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] activity,
  input  logic       rx_first_stored,
  input  logic       tx_first_taken,
  input  logic       coll,
  input  logic       backoff_done,
  input  logic       det_res_en,
  input  logic       frame_done,
  input  logic       tx_en_set,
  input  logic       rx_err_clr,
  input  logic       tx_err_clr,
  output logic       rx_abort,
  output logic       rx_en_clr,
  output logic       rx_err,
  output logic       jam_start,
  output logic       tx_restart,
  output logic       tx_en_clr,
  output logic       tx_err,
  output logic       res_start
);
  localparam int unsigned NFLAG = 2;

  resp_t            resp;
  logic             at_limit;
  logic             restart_fire;
  logic             restart_pending;
  logic [CNT_W-1:0] retry_cnt;
  logic             count_clr;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  assign count_clr = frame_done | tx_en_set;

  crc_classify u_cls (
    .coll(coll), .activity(activity), .rx_first_stored(rx_first_stored),
    .tx_first_taken(tx_first_taken), .at_limit(at_limit),
    .det_res_en(det_res_en), .resp(resp)
  );

  crc_retry_ctr #(.CNT_W(CNT_W), .MAX_RESTARTS(MAX_RESTARTS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .arm(resp.want_retry), .backoff_done(backoff_done),
    .clr(count_clr), .fire(restart_fire), .at_limit(at_limit),
    .pending(restart_pending), .count(retry_cnt)
  );

  assign flag_set = {resp.tx_fail, resp.rx_err_set};
  assign flag_clr = {tx_err_clr, rx_err_clr};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    crc_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clr[g]), .flag(flag_q[g])
    );
  end

  assign rx_err = flag_q[0];
  assign tx_err = flag_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_abort   <= 1'b0;
      rx_en_clr  <= 1'b0;
      jam_start  <= 1'b0;
      tx_restart <= 1'b0;
      tx_en_clr  <= 1'b0;
      res_start  <= 1'b0;
    end else begin
      rx_abort   <= resp.rx_abort;
      rx_en_clr  <= resp.rx_en_clr;
      jam_start  <= resp.jam;
      tx_restart <= restart_fire;
      tx_en_clr  <= resp.tx_fail;
      res_start  <= resp.res_start;
    end
  end
endmodule

// File: rtl/crc_resp_chk.sv
module crc_resp_chk #(
  parameter int unsigned CNT_W        = 4,
  parameter int unsigned MAX_RESTARTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       activity,
  input logic             rx_first_stored,
  input logic             coll,
  input logic             backoff_done,
  input logic             det_res_en,
  input logic             rx_err_clr,
  input logic             tx_err_clr,
  input logic             rx_abort,
  input logic             rx_en_clr,
  input logic             rx_err,
  input logic             jam_start,
  input logic             tx_restart,
  input logic             tx_en_clr,
  input logic             tx_err,
  input logic             res_start,
  input logic             restart_pending,
  input logic [CNT_W-1:0] retry_cnt
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll && activity[0] == activity[1] |=> !rx_abort && !rx_en_clr && !jam_start && !tx_en_clr);
  // R2
  res_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_start |-> $past(coll) && $past(det_res_en) && $past(activity) != 2'b10);
  // R4
  rx_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_clr |-> $past(rx_first_stored) && rx_err && rx_abort);
  // R3
  rx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll && activity == 2'b01 && !rx_first_stored && !rx_err |=> !rx_err && !rx_en_clr);
  // R5
  tx_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll && activity == 2'b10 |=> jam_start && !res_start);
  // R6
  restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_restart |-> $past(backoff_done) && $past(restart_pending));
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retry_cnt) <= MAX_RESTARTS);
  // R10
  rx_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err && !rx_err_clr |=> rx_err);
  // R10
  tx_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err && !tx_err_clr |=> tx_err);
endmodule

bind collision_resp_ctrl crc_resp_chk #(.CNT_W(CNT_W), .MAX_RESTARTS(MAX_RESTARTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .activity(activity), .rx_first_stored(rx_first_stored),
  .coll(coll), .backoff_done(backoff_done), .det_res_en(det_res_en),
  .rx_err_clr(rx_err_clr), .tx_err_clr(tx_err_clr), .rx_abort(rx_abort),
  .rx_en_clr(rx_en_clr), .rx_err(rx_err), .jam_start(jam_start), .tx_restart(tx_restart),
  .tx_en_clr(tx_en_clr), .tx_err(tx_err), .res_start(res_start),
  .restart_pending(restart_pending), .retry_cnt(retry_cnt)
);

// File: tb/tb_collision_resp_ctrl.sv
`timescale 1ns/1ps
module tb_collision_resp_ctrl;
  localparam int LIM = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] activity = 2'b00;
  logic rx_first_stored = 0, tx_first_taken = 0, coll = 0, backoff_done = 0;
  logic det_res_en = 0, frame_done = 0, tx_en_set = 0, rx_err_clr = 0, tx_err_clr = 0;
  logic rx_abort, rx_en_clr, rx_err, jam_start, tx_restart, tx_en_clr, tx_err, res_start;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference state
  int m_restarts = 0;
  bit m_armed = 0;
  bit e_abort, e_rxclr, e_rxerr, e_jam, e_rst, e_txclr, e_txerr, e_res;

  always #2.5 clk = ~clk;

  collision_resp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .activity(activity), .rx_first_stored(rx_first_stored),
    .tx_first_taken(tx_first_taken), .coll(coll), .backoff_done(backoff_done),
    .det_res_en(det_res_en), .frame_done(frame_done), .tx_en_set(tx_en_set),
    .rx_err_clr(rx_err_clr), .tx_err_clr(tx_err_clr), .rx_abort(rx_abort),
    .rx_en_clr(rx_en_clr), .rx_err(rx_err), .jam_start(jam_start), .tx_restart(tx_restart),
    .tx_en_clr(tx_en_clr), .tx_err(tx_err), .res_start(res_start)
  );

  always @(posedge clk) begin
    bit fire, arm, rxset, txset;
    if (!rst_n) begin
      {e_abort, e_rxclr, e_rxerr, e_jam, e_rst, e_txclr, e_txerr, e_res} = '0;
      m_restarts = 0; m_armed = 0;
    end else begin
      fire = m_armed && backoff_done;
      arm = 0; rxset = 0; txset = 0;
      {e_abort, e_rxclr, e_jam, e_rst, e_txclr, e_res} = '0;
      if (coll) begin
        if (activity == 2'b01) begin
          e_abort = 1; e_rxclr = rx_first_stored; rxset = rx_first_stored; e_res = det_res_en;
        end else if (activity == 2'b10) begin
          e_jam = 1;
          if (tx_first_taken || m_restarts >= LIM) begin e_txclr = 1; txset = 1; end
          else arm = 1;
        end else e_res = det_res_en;
      end
      if (fire) begin e_rst = 1; m_restarts++; m_armed = 0; end
      if (arm) m_armed = 1;
      if (frame_done || tx_en_set) begin m_restarts = 0; m_armed = 0; end
      e_rxerr = rxset ? 1'b1 : (rx_err_clr ? 1'b0 : e_rxerr);
      e_txerr = txset ? 1'b1 : (tx_err_clr ? 1'b0 : e_txerr);
    end
  end

  task automatic cmp(string nm, logic got, bit exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, nm, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    cmp("rx_abort", rx_abort, e_abort);
    cmp("rx_en_clr", rx_en_clr, e_rxclr);
    cmp("rx_err", rx_err, e_rxerr);
    cmp("jam_start", jam_start, e_jam);
    cmp("tx_restart", tx_restart, e_rst);
    cmp("tx_en_clr", tx_en_clr, e_txclr);
    cmp("tx_err", tx_err, e_txerr);
    cmp("res_start", res_start, e_res);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hit(logic [1:0] act, bit st, bit tk, bit en);
    @(negedge clk);
    activity = act; rx_first_stored = st; tx_first_taken = tk; det_res_en = en; coll = 1;
    @(negedge clk);
    coll = 0;
    idle(2);
  endtask

  task automatic pulse_backoff();
    @(negedge clk); backoff_done = 1;
    @(negedge clk); backoff_done = 0;
    idle(2);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
    idle(1);
  endtask

  // directed port-level checks beyond the per-cycle comparison
  task automatic expect_bit(string nm, logic got, bit exp);
    cmp(nm, got, exp);
  endtask

  initial begin
    cur_req = "R1";
    idle(4);
    @(negedge clk); rst_n = 1;
    idle(3);

    cur_req = "R2";
    hit(2'b00, 0, 0, 0);
    hit(2'b00, 0, 0, 1);
    hit(2'b11, 1, 1, 1);

    cur_req = "R3";
    hit(2'b01, 0, 0, 0);
    hit(2'b01, 0, 0, 1);

    cur_req = "R4";
    hit(2'b01, 1, 0, 1);
    hit(2'b01, 1, 0, 0);

    cur_req = "R10";
    idle(5);
    expect_bit("rx_err held", rx_err, 1'b1);
    pulse(rx_err_clr);
    expect_bit("rx_err cleared", rx_err, 1'b0);
    @(negedge clk);
    activity = 2'b01; rx_first_stored = 1; coll = 1; rx_err_clr = 1;
    @(negedge clk); coll = 0; rx_err_clr = 0;
    expect_bit("rx_err set wins", rx_err, 1'b1);
    pulse(rx_err_clr);

    cur_req = "R8";
    pulse(tx_en_set);
    hit(2'b10, 0, 1, 1);
    cur_req = "R11";
    pulse_backoff();
    expect_bit("no restart after taken", tx_restart, 1'b0);
    cur_req = "R10";
    idle(3);
    expect_bit("tx_err held", tx_err, 1'b1);
    pulse(tx_err_clr);

    cur_req = "R5";
    pulse(tx_en_set);
    hit(2'b10, 0, 0, 1);
    cur_req = "R6";
    pulse_backoff();

    cur_req = "R9";
    pulse(frame_done);
    for (int i = 0; i < LIM; i++) begin
      hit(2'b10, 0, 0, 0);
      pulse_backoff();
      if (i == 3) begin pulse(tx_en_set); end
    end
    for (int i = 0; i < 4; i++) begin
      hit(2'b10, 0, 0, 0);
      pulse_backoff();
    end
    cur_req = "R7";
    hit(2'b10, 0, 0, 0);
    expect_bit("tx_err at limit", tx_err, 1'b1);
    cur_req = "R11";
    pulse_backoff();
    pulse_backoff();
    pulse(tx_err_clr);

    cur_req = "R9";
    pulse(tx_en_set);
    hit(2'b10, 0, 0, 0);
    pulse_backoff();
    expect_bit("tx_err clear after fresh start", tx_err, 1'b0);

    cur_req = "R1";
    @(negedge clk); rst_n = 0;
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog %s: got running expected done", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule